// File: doc/BRIEF.md
# ADC Channel Sequencer and Trigger Controller

This block sits in front of an eight-input successive-approximation converter. It decides when each conversion begins and which input the analog multiplexer presents. A byte-wide configuration register sets four things: a channel number, whether starts come from software or from hardware, which hardware source is used (an asynchronous trigger pin or a timer event), and which pin edges count. A two-bit control register holds the converter enable and the choice between single-channel and scan sequencing.

In single-channel mode the chosen input is converted repeatedly. In scan mode the multiplexer select walks from input 0 up to the programmed channel, advancing on each converter done pulse, and then returns to 0. In software mode, setting the enable starts conversions, and they restart by themselves for as long as the enable stays set. In hardware mode, every pass waits for a new qualified trigger. The converter is represented only by its done pulse.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, cfg_rdata is 0x00, the control register is cleared (enable 0, scan 0), conv_busy and conv_start are 0, and chan_sel is 0.
- R2: Configuration byte layout: bits [2:0] hold the channel, bit 3 is reserved, bits [5:4] are the edge field, bit 6 is the hardware source (0 pin, 1 timer), and bit 7 is the trigger mode (0 software, 1 hardware). Bit 3 always reads 0, whatever value is written.
- R3: Control register (reg_addr 1): bit 0 is the enable and bit 1 selects scan. In software mode, conv_start pulses for one cycle on the second clock edge after the write that sets the enable. A new pass starts one cycle after each pass ends, for as long as the enable stays set.
- R4: In single-channel mode, chan_sel equals the configured channel from the start pulse on. conv_busy rises together with conv_start and falls on the next conv_done.
- R5: In scan mode the first start selects channel 0. Each conv_done before the last channel raises chan_sel by one and issues a new conv_start. The conv_done of the configured channel clears conv_busy and returns chan_sel to 0.
- R6: With hardware mode and the pin source selected, the edge field is decoded as follows: 00 means no edge is detected, 01 means falling, 10 means rising, and 11 means both. A qualifying pin change causes conv_start on the third clock edge after the change (two synchronizer stages, then one more edge).
- R7: The edge field has no effect unless hardware mode and the pin source are both selected. With the timer source, pin changes never start a conversion.
- R8: With hardware mode and the timer source, a one-cycle timer_evt starts a conversion on the next edge. With the pin source, timer_evt is ignored.
- R9: While conv_busy is high, writes to the configuration register are dropped, and software or hardware triggers cause no additional start.
- R10: In hardware mode, once a pass ends, no further conversion starts until a new trigger arrives.
- R11: A control write that clears the enable aborts the sequence on that edge: conv_busy goes to 0, chan_sel goes to 0, and no further starts follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the configuration byte, 1 selects the control register |
| reg_wdata | input | 8 | Write data |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| timer_evt | input | 1 | One-cycle timer event |
| conv_done | input | 1 | One-cycle pulse from the converter when a conversion finishes |
| cfg_rdata | output | 8 | Current configuration byte |
| conv_start | output | 1 | One-cycle pulse that starts a conversion |
| chan_sel | output | 3 | Analog multiplexer select |
| conv_busy | output | 1 | Conversion sequence in progress |

## Verification
The assertions rely on conv_done arriving only while conv_busy is high. They also rely on timer_evt being a single-cycle pulse. The bench therefore pulses conv_done only after it has seen a start, and holds timer_evt for exactly one clock. Pin changes are spaced at least four clocks apart so the synchronizer settles between them. Configuration writes are issued while idle, except for the deliberate writes made while busy.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W = 3;
  localparam int NUM_CH = 1 << CH_W;
  localparam int CFG_W = 8;

  localparam int CFG_RSVD_BIT = 3;
  localparam int CFG_EDGE_LO = 4;
  localparam int CFG_SRC_BIT = 6;
  localparam int CFG_MODE_BIT = 7;

  localparam int CTL_EN_BIT = 0;
  localparam int CTL_SCAN_BIT = 1;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_t;
endpackage

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             addr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             busy,
  output logic [CFG_W-1:0] cfg_q,
  output logic             en,
  output logic             scan,
  output logic             abort
);
  localparam logic [CFG_W-1:0] RSVD_MASK = ~(CFG_W'(1) << CFG_RSVD_BIT);

  logic cfg_wr;
  logic ctl_wr;

  assign cfg_wr = wr && !addr && !busy;
  assign ctl_wr = wr && addr;
  assign abort  = ctl_wr && !wdata[CTL_EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      en    <= 1'b0;
      scan  <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= wdata & RSVD_MASK;
      if (ctl_wr) begin
        en   <= wdata[CTL_EN_BIT];
        scan <= wdata[CTL_SCAN_BIT];
      end
    end
  end

  // R2: reserved bit reads back 0 after any accepted write
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    (wr && !addr && !busy) |=> !cfg_q[CFG_RSVD_BIT]);

  // R9: configuration held while a conversion is running
  a_r9_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    (wr && !addr && busy) |=> $stable(cfg_q));
endmodule

// File: rtl/adc_trig_qual.sv
module adc_trig_qual
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pin,
  input  logic      tmr_evt,
  input  logic      hw_mode,
  input  logic      src_tmr,
  input  edge_sel_t edge_sel,
  output logic      start_req
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise;
  logic                   fall;
  logic                   pin_hit;
  logic                   hw_hit;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[LAST];
  end

  assign rise = sync_q[LAST] && !prev_q;
  assign fall = !sync_q[LAST] && prev_q;

  always_comb begin
    unique case (edge_sel)
      EDGE_NONE: pin_hit = 1'b0;
      EDGE_FALL: pin_hit = fall;
      EDGE_RISE: pin_hit = rise;
      EDGE_BOTH: pin_hit = rise || fall;
      default:   pin_hit = 1'b0;
    endcase
  end

  assign hw_hit    = src_tmr ? tmr_evt : pin_hit;
  assign start_req = hw_mode ? hw_hit : 1'b1;
endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
  import adc_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            scan,
  input  logic [CH_W-1:0] chan,
  input  logic            start_req,
  input  logic            conv_done,
  input  logic            abort,
  output logic            conv_start,
  output logic [CH_W-1:0] mux_sel,
  output logic            busy
);
  logic at_last;
  assign at_last = !scan || (mux_sel == chan);

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_start <= 1'b0;
      mux_sel    <= '0;
      busy       <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      if (abort) begin
        busy    <= 1'b0;
        mux_sel <= '0;
      end else if (busy) begin
        if (conv_done) begin
          if (!at_last) begin
            mux_sel    <= mux_sel + CH_W'(1);
            conv_start <= 1'b1;
          end else begin
            busy <= 1'b0;
            if (scan) mux_sel <= '0;
          end
        end
      end else if (en && start_req) begin
        busy       <= 1'b1;
        conv_start <= 1'b1;
        mux_sel    <= scan ? '0 : chan;
      end
    end
  end

  // R4: start pulse only while a sequence is active
  a_r4_start_busy: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy);

  // R9: no start while a conversion runs, except the scan step on done
  a_r9_no_retrig: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> (!$past(busy) || $past(conv_done)));

  // R5: scan select never passes the last channel
  a_r5_scan_bound: assert property (@(posedge clk) disable iff (rst)
    (busy && scan) |-> (mux_sel <= chan));

  // R5: done on the last channel ends the pass
  a_r5_pass_end: assert property (@(posedge clk) disable iff (rst)
    (busy && scan && conv_done && mux_sel == chan && !abort) |=> !busy);

  // R11: abort clears sequence state on the write edge
  a_r11_abort: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!busy && mux_sel == '0));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [CFG_W-1:0] reg_wdata,
  input  logic             trig_pin,
  input  logic             timer_evt,
  input  logic             conv_done,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             conv_start,
  output logic [CH_W-1:0]  chan_sel,
  output logic             conv_busy
);
  logic      en;
  logic      scan;
  logic      abort;
  logic      start_req;
  edge_sel_t edge_sel;

  adc_cfg_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .busy  (conv_busy),
    .cfg_q (cfg_rdata),
    .en    (en),
    .scan  (scan),
    .abort (abort)
  );

  assign edge_sel = edge_sel_t'(cfg_rdata[CFG_EDGE_LO +: 2]);

  adc_trig_qual #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk       (clk),
    .rst       (rst),
    .pin       (trig_pin),
    .tmr_evt   (timer_evt),
    .hw_mode   (cfg_rdata[CFG_MODE_BIT]),
    .src_tmr   (cfg_rdata[CFG_SRC_BIT]),
    .edge_sel  (edge_sel),
    .start_req (start_req)
  );

  adc_chan_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .scan       (scan),
    .chan       (cfg_rdata[CH_W-1:0]),
    .start_req  (start_req),
    .conv_done  (conv_done),
    .abort      (abort),
    .conv_start (conv_start),
    .mux_sel    (chan_sel),
    .busy       (conv_busy)
  );
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       trig_pin = 1'b0;
  logic       timer_evt = 1'b0;
  logic       conv_done = 1'b0;
  logic [7:0] cfg_rdata;
  logic       conv_start;
  logic [2:0] chan_sel;
  logic       conv_busy;

  int n_checks = 0;
  int n_fail = 0;

  // per entry: {edge[1:0], rising_change, start_expected}
  localparam logic [3:0] EDGE_VEC [8] = '{
    4'b00_1_0, 4'b00_0_0, 4'b01_1_0, 4'b01_0_1,
    4'b10_1_1, 4'b10_0_0, 4'b11_1_1, 4'b11_0_1
  };

  always #10 clk = ~clk;

  adc_seq_ctrl uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .trig_pin(trig_pin), .timer_evt(timer_evt),
    .conv_done(conv_done), .cfg_rdata(cfg_rdata), .conv_start(conv_start),
    .chan_sel(chan_sel), .conv_busy(conv_busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic done_pulse();
    conv_done = 1'b1;
    tick();
    conv_done = 1'b0;
  endtask

  task automatic fire_timer();
    timer_evt = 1'b1;
    tick();
    timer_evt = 1'b0;
  endtask

  task automatic wait_start(input int max_cyc, output int n);
    n = 0;
    for (int i = 1; i <= max_cyc; i++) begin
      tick();
      if (conv_start) begin
        n = i;
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 cfg reset", cfg_rdata, 0);
    check("R1 busy reset", conv_busy, 0);
    check("R1 start reset", conv_start, 0);
    check("R1 sel reset", chan_sel, 0);
    wait_start(3, n);
    check("R1 no start while disabled", n, 0);

    // R2 reserved bit
    wr(1'b0, 8'hFF);
    check("R2 rsvd masked", cfg_rdata, 8'hF7);
    wr(1'b0, 8'h08);
    check("R2 rsvd only", cfg_rdata, 0);

    // R3 / R4 software single-channel
    wr(1'b0, 8'h06);
    wr(1'b1, 8'h01);
    tick();
    check("R3 sw start", conv_start, 1);
    check("R4 busy rises", conv_busy, 1);
    check("R4 sel chan", chan_sel, 6);
    tick();
    check("R3 single pulse", conv_start, 0);
    done_pulse();
    check("R4 busy falls", conv_busy, 0);
    tick();
    check("R3 auto restart", conv_start, 1);
    check("R4 sel again", chan_sel, 6);
    done_pulse();
    wr(1'b1, 8'h00);
    check("R11 idle after disable", conv_busy, 0);

    // R5 software scan to channel 3
    wr(1'b0, 8'h03);
    wr(1'b1, 8'h03);
    tick();
    check("R5 scan start", conv_start, 1);
    for (int k = 0; k < 4; k++) begin
      check("R5 sel step", chan_sel, k);
      done_pulse();
      if (k < 3) begin
        check("R5 next start", conv_start, 1);
        check("R5 busy mid", conv_busy, 1);
      end else begin
        check("R5 pass end busy", conv_busy, 0);
        check("R5 wrap sel", chan_sel, 0);
      end
    end
    tick();
    check("R3 scan restart", conv_start, 1);
    done_pulse();
    done_pulse();
    check("R5 mid sel", chan_sel, 2);
    wr(1'b1, 8'h02);
    check("R11 abort busy", conv_busy, 0);
    check("R11 abort sel", chan_sel, 0);
    wait_start(3, n);
    check("R11 no start after abort", n, 0);

    // R6 edge table, hardware pin source, channel 2
    for (int v = 0; v < 8; v++) begin
      logic [1:0] e;
      logic rising;
      logic exp_hit;
      {e, rising, exp_hit} = EDGE_VEC[v];
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h82 | {2'b00, e, 4'h0});
      trig_pin = !rising;
      repeat (4) tick();
      wr(1'b1, 8'h01);
      trig_pin = rising;
      wait_start(5, n);
      check("R6 edge start latency", n, exp_hit ? 3 : 0);
      if (n != 0) begin
        check("R6 sel", chan_sel, 2);
        done_pulse();
        check("R6 busy end", conv_busy, 0);
      end
    end

    // R7 / R8 timer source, edge field 11
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hF1);
    wr(1'b1, 8'h01);
    trig_pin = 1'b1;
    wait_start(5, n);
    check("R7 pin ignored rise", n, 0);
    trig_pin = 1'b0;
    wait_start(5, n);
    check("R7 pin ignored fall", n, 0);
    fire_timer();
    check("R8 timer start", conv_start, 1);
    check("R8 sel", chan_sel, 1);
    fire_timer();
    check("R9 timer ignored busy", conv_start, 0);
    wr(1'b0, 8'h00);
    check("R9 cfg write dropped", cfg_rdata, 8'hF1);
    done_pulse();
    check("R9 busy end", conv_busy, 0);

    // R8 timer ignored with pin source; R9 pin ignored while busy
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hB0);
    wr(1'b1, 8'h01);
    fire_timer();
    check("R8 timer ignored pin src", conv_start, 0);
    wait_start(3, n);
    check("R8 no late start", n, 0);
    trig_pin = 1'b1;
    wait_start(5, n);
    check("R6 pin start", n, 3);
    trig_pin = 1'b0;
    wait_start(5, n);
    check("R9 pin ignored busy", n, 0);
    done_pulse();
    check("R9 busy end pin", conv_busy, 0);

    // R10 hardware scan needs a new trigger
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hC1);
    wr(1'b1, 8'h03);
    fire_timer();
    check("R10 first start", conv_start, 1);
    check("R10 sel0", chan_sel, 0);
    done_pulse();
    check("R10 step start", conv_start, 1);
    check("R10 sel1", chan_sel, 1);
    done_pulse();
    check("R10 pass end", conv_busy, 0);
    wait_start(4, n);
    check("R10 no auto restart", n, 0);
    fire_timer();
    check("R10 retrigger", conv_start, 1);
    check("R10 retrigger sel", chan_sel, 0);
    wr(1'b1, 8'h00);
    check("R11 final abort", conv_busy, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule